// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block runs the exception side of a small 8-bit CPU core. At an instruction boundary it decides whether to enter an interrupt. The trigger is either an unmasked hardware request or a software-interrupt instruction. On entry it saves the running context onto a byte-wide stack that grows downward, and it raises the interrupt mask bit in the condition code register. It then reads the two-byte vector of the most urgent pending source and fills the core's three-byte instruction queue from the vector target. When the decoder reports a return-from-interrupt instruction, it pulls the saved context back off the stack in the opposite order.

The core keeps its own register file. The sequencer samples the program counter, index-low, accumulator, condition code register and stack pointer through plain input ports when a sequence starts. It writes results back through load strobes, each paired with a data value. All stack, vector and program traffic goes over one byte-wide memory port whose read data is valid in the same cycle as the address. The index-high register takes no part in either sequence.

Top module: `irq_seq`

## Requirements
- R1: A hardware request is taken only at a posedge where `instrDone` is high and bit 3 of `ccrIn` (the mask bit) is 0; `busy` rises in the next cycle. With the mask set, or with `instrDone` low, pending requests start nothing.
- R2: An entry makes exactly five writes in back-to-back cycles, at addresses SP, SP-1, SP-2, SP-3 and SP-4, where SP is `spIn` at the start. The bytes written are PC[7:0], PC[15:8], X, A and CCR, in that order. The PC is the sampled `pcIn` and the CCR is the sampled `ccrIn`, written with its mask bit unchanged.
- R3: The cycle after the last write pulses `ccrLoad` and `spLoad` together. `ccrOut` is the sampled CCR with bit 3 set, and `spOut` is SP-5.
- R4: Line 0 has the highest priority. Line k owns a vector at 0xFFFA - 2k, with the high byte at the lower address. The source is chosen in the first vector-read cycle from the lines pending in that cycle. If no line is pending then, the source chosen at the start is used.
- R5: `swiReq` at an instruction boundary starts the same entry whatever the mask bit is, and it uses the vector at 0xFFFC. If an unmasked hardware request is pending at the same boundary, the hardware request is taken first.
- R6: After the vector reads come three reads at T, T+1 and T+2, where T is the fetched vector value. Each read pulses `qWr` with `qIdx` 0, 1, 2 and `qData` equal to the byte read. The third read also loads the PC with T+3.
- R7: `rtiReq` at a boundary where no entry is taken makes five reads at SP+1 through SP+5. These load CCR, A, X, PC[15:8] and PC[7:0]; the full PC and `spOut` = SP+5 are loaded in the last of them.
- R8: `busy` is high for exactly 10 cycles per entry and exactly 5 per return. While it is high, no new request, software interrupt or return is acted on.
- R9: During reset `busy`, `memWr`, `memRd`, `qWr` and every load strobe are low.
- R10: `memWr` and `memRd` are never high together, and neither is high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| instrDone | input | 1 | Current instruction has completed (boundary) |
| irqReq | input | NUM_SRC | Hardware interrupt request lines, line 0 most urgent |
| swiReq | input | 1 | Software-interrupt instruction decoded |
| rtiReq | input | 1 | Return-from-interrupt instruction decoded |
| pcIn | input | 16 | Address of the next instruction |
| xIn | input | 8 | Index-low register |
| aIn | input | 8 | Accumulator |
| ccrIn | input | 8 | Condition code register, bit 3 is the mask |
| spIn | input | 16 | Stack pointer (next free byte) |
| memAddr | output | 16 | Memory address |
| memWr | output | 1 | Memory write strobe |
| memRd | output | 1 | Memory read strobe |
| memWdata | output | 8 | Memory write data |
| memRdata | input | 8 | Memory read data, valid in the same cycle |
| busy | output | 1 | Sequence in progress |
| pcLoad | output | 1 | Load program counter |
| pcOut | output | 16 | Program counter value |
| xLoad | output | 1 | Load index-low register |
| xOut | output | 8 | Index-low value |
| aLoad | output | 1 | Load accumulator |
| aOut | output | 8 | Accumulator value |
| ccrLoad | output | 1 | Load condition code register |
| ccrOut | output | 8 | Condition code value |
| spLoad | output | 1 | Load stack pointer |
| spOut | output | 16 | Stack pointer value |
| qWr | output | 1 | Instruction queue write |
| qIdx | output | 2 | Instruction queue slot |
| qData | output | 8 | Instruction queue byte |

## Verification
The bench sweeps every request line with all less urgent lines also pending. A broken priority encoder would fetch the wrong vector, and a stacking slip would leave bytes out of order or put the final stack pointer one byte off. It raises a more urgent line in the middle of the pushes and drops a line before the vector read. A design that latched its source too early, or lost it, would jump to the wrong target. It also runs a nested entry after the ISR has cleared the mask, a masked request that waits for the return, and a software interrupt that arrives together with a hardware one. These catch a mask bit that is set too late or restored wrongly, and a software interrupt that wrongly overrides the hardware request.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;

  typedef enum logic [4:0] {
    S_IDLE, S_PUSH_PCL, S_PUSH_PCH, S_PUSH_X, S_PUSH_A, S_PUSH_CCR,
    S_VEC_HI, S_VEC_LO, S_FILL0, S_FILL1, S_FILL2,
    S_POP_CCR, S_POP_A, S_POP_X, S_POP_PCH, S_POP_PCL
  } seqState_e;

  typedef enum logic [2:0] {
    B_NONE, B_PCL, B_PCH, B_X, B_A, B_CCR
  } ctxByte_e;

  typedef struct packed {
    logic     capture;
    logic     useSwi;
    logic     push;
    logic     pop;
    ctxByte_e byteSel;
    logic     vecHi;
    logic     vecLo;
    logic     fill;
    logic [1:0] fillIdx;
  } seqCtl_t;
endpackage

// File: rtl/irq_seq_prio.sv
module irq_seq_prio #(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_SRC-1:0] req,
  output logic               anyReq,
  output logic [IDX_W-1:0]   winIdx
);
  // lowest index wins: scan from the top so the last hit is the smallest
  always_comb begin
    anyReq = |req;
    winIdx = '0;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (req[k]) winIdx = IDX_W'(k);
    end
  end
endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    instrDone,
  input  logic    anyReq,
  input  logic    swiReq,
  input  logic    rtiReq,
  input  logic    maskBit,
  output seqCtl_t ctl,
  output logic    busy
);
  seqState_e state, nextState;
  logic kindSwi;
  logic takeIrq, takeSwi, takeRti, startAny;

  always_comb begin
    takeIrq  = instrDone && anyReq && !maskBit;
    takeSwi  = instrDone && swiReq && !takeIrq;
    takeRti  = instrDone && rtiReq && !takeIrq && !takeSwi;
    startAny = takeIrq || takeSwi || takeRti;
  end

  always_comb begin
    nextState = state;
    case (state)
      S_IDLE: begin
        if (takeIrq || takeSwi) nextState = S_PUSH_PCL;
        else if (takeRti)       nextState = S_POP_CCR;
      end
      S_PUSH_PCL: nextState = S_PUSH_PCH;
      S_PUSH_PCH: nextState = S_PUSH_X;
      S_PUSH_X:   nextState = S_PUSH_A;
      S_PUSH_A:   nextState = S_PUSH_CCR;
      S_PUSH_CCR: nextState = S_VEC_HI;
      S_VEC_HI:   nextState = S_VEC_LO;
      S_VEC_LO:   nextState = S_FILL0;
      S_FILL0:    nextState = S_FILL1;
      S_FILL1:    nextState = S_FILL2;
      S_FILL2:    nextState = S_IDLE;
      S_POP_CCR:  nextState = S_POP_A;
      S_POP_A:    nextState = S_POP_X;
      S_POP_X:    nextState = S_POP_PCH;
      S_POP_PCH:  nextState = S_POP_PCL;
      S_POP_PCL:  nextState = S_IDLE;
      default:    nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      kindSwi <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_IDLE && startAny) kindSwi <= takeSwi;
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.capture  = (state == S_IDLE) && startAny;
    ctl.useSwi   = kindSwi;
    ctl.byteSel  = B_NONE;
    case (state)
      S_PUSH_PCL: begin ctl.push = 1'b1; ctl.byteSel = B_PCL; end
      S_PUSH_PCH: begin ctl.push = 1'b1; ctl.byteSel = B_PCH; end
      S_PUSH_X:   begin ctl.push = 1'b1; ctl.byteSel = B_X;   end
      S_PUSH_A:   begin ctl.push = 1'b1; ctl.byteSel = B_A;   end
      S_PUSH_CCR: begin ctl.push = 1'b1; ctl.byteSel = B_CCR; end
      S_VEC_HI:   ctl.vecHi = 1'b1;
      S_VEC_LO:   ctl.vecLo = 1'b1;
      S_FILL0:    begin ctl.fill = 1'b1; ctl.fillIdx = 2'd0; end
      S_FILL1:    begin ctl.fill = 1'b1; ctl.fillIdx = 2'd1; end
      S_FILL2:    begin ctl.fill = 1'b1; ctl.fillIdx = 2'd2; end
      S_POP_CCR:  begin ctl.pop = 1'b1; ctl.byteSel = B_CCR; end
      S_POP_A:    begin ctl.pop = 1'b1; ctl.byteSel = B_A;   end
      S_POP_X:    begin ctl.pop = 1'b1; ctl.byteSel = B_X;   end
      S_POP_PCH:  begin ctl.pop = 1'b1; ctl.byteSel = B_PCH; end
      S_POP_PCL:  begin ctl.pop = 1'b1; ctl.byteSel = B_PCL; end
      default: ;
    endcase
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/irq_seq_dp.sv
module irq_seq_dp
  import irq_seq_pkg::*;
#(
  parameter int    IDX_W   = 3,
  parameter int    I_BIT   = 3,
  parameter addr_t VEC_TOP = 16'hFFFA,
  parameter addr_t SWI_VEC = 16'hFFFC
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqCtl_t          ctl,
  input  logic             curAny,
  input  logic [IDX_W-1:0] curIdx,
  input  addr_t            pcIn,
  input  byte_t            xIn,
  input  byte_t            aIn,
  input  byte_t            ccrIn,
  input  addr_t            spIn,
  input  byte_t            memRdata,
  output addr_t            memAddr,
  output logic             memWr,
  output logic             memRd,
  output byte_t            memWdata,
  output logic             pcLoad,
  output addr_t            pcOut,
  output logic             xLoad,
  output byte_t            xOut,
  output logic             aLoad,
  output byte_t            aOut,
  output logic             ccrLoad,
  output byte_t            ccrOut,
  output logic             spLoad,
  output addr_t            spOut,
  output logic             qWr,
  output logic [1:0]       qIdx,
  output byte_t            qData
);
  localparam byte_t MASK_SET = byte_t'(1 << I_BIT);

  addr_t savedPc, sp, vecBase, target;
  byte_t savedX, savedA, savedCcr, vecHiByte, popPcHi;
  logic [IDX_W-1:0] startIdx;
  logic [IDX_W-1:0] selIdx;
  addr_t selVec, spUp;

  always_comb begin
    selIdx = curAny ? curIdx : startIdx;
    selVec = ctl.useSwi ? SWI_VEC : (VEC_TOP - (addr_t'(selIdx) << 1));
    spUp   = sp + addr_t'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      savedPc   <= '0;
      savedX    <= '0;
      savedA    <= '0;
      savedCcr  <= '0;
      sp        <= '0;
      startIdx  <= '0;
      vecBase   <= '0;
      vecHiByte <= '0;
      target    <= '0;
      popPcHi   <= '0;
    end else begin
      if (ctl.capture) begin
        savedPc  <= pcIn;
        savedX   <= xIn;
        savedA   <= aIn;
        savedCcr <= ccrIn;
        sp       <= spIn;
        startIdx <= curIdx;
      end
      if (ctl.push) sp <= sp - addr_t'(1);
      if (ctl.pop)  sp <= spUp;
      if (ctl.vecHi) begin
        vecBase   <= selVec;
        vecHiByte <= memRdata;
      end
      if (ctl.vecLo) target <= {vecHiByte, memRdata};
      if (ctl.pop && ctl.byteSel == B_PCH) popPcHi <= memRdata;
    end
  end

  // memory port
  always_comb begin
    memWr    = ctl.push;
    memRd    = ctl.pop || ctl.vecHi || ctl.vecLo || ctl.fill;
    memAddr  = '0;
    if (ctl.push)       memAddr = sp;
    else if (ctl.pop)   memAddr = spUp;
    else if (ctl.vecHi) memAddr = selVec;
    else if (ctl.vecLo) memAddr = vecBase + addr_t'(1);
    else if (ctl.fill)  memAddr = target + addr_t'(ctl.fillIdx);
    case (ctl.byteSel)
      B_PCL:   memWdata = savedPc[7:0];
      B_PCH:   memWdata = savedPc[15:8];
      B_X:     memWdata = savedX;
      B_A:     memWdata = savedA;
      B_CCR:   memWdata = savedCcr;
      default: memWdata = '0;
    endcase
  end

  // register load hooks
  always_comb begin
    ccrLoad = ctl.vecHi || (ctl.pop && ctl.byteSel == B_CCR);
    ccrOut  = ctl.vecHi ? (savedCcr | MASK_SET) : memRdata;
    aLoad   = ctl.pop && ctl.byteSel == B_A;
    aOut    = memRdata;
    xLoad   = ctl.pop && ctl.byteSel == B_X;
    xOut    = memRdata;
    pcLoad  = (ctl.fill && ctl.fillIdx == 2'd2) || (ctl.pop && ctl.byteSel == B_PCL);
    pcOut   = ctl.fill ? (target + addr_t'(3)) : {popPcHi, memRdata};
    spLoad  = ctl.vecHi || (ctl.pop && ctl.byteSel == B_PCL);
    spOut   = ctl.vecHi ? sp : spUp;
    qWr     = ctl.fill;
    qIdx    = ctl.fillIdx;
    qData   = memRdata;
  end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_seq_pkg::*;
#(
  parameter int    NUM_SRC = 8,
  parameter int    I_BIT   = 3,
  parameter addr_t VEC_TOP = 16'hFFFA,
  parameter addr_t SWI_VEC = 16'hFFFC
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrDone,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic               swiReq,
  input  logic               rtiReq,
  input  logic [15:0]        pcIn,
  input  logic [7:0]         xIn,
  input  logic [7:0]         aIn,
  input  logic [7:0]         ccrIn,
  input  logic [15:0]        spIn,
  output logic [15:0]        memAddr,
  output logic               memWr,
  output logic               memRd,
  output logic [7:0]         memWdata,
  input  logic [7:0]         memRdata,
  output logic               busy,
  output logic               pcLoad,
  output logic [15:0]        pcOut,
  output logic               xLoad,
  output logic [7:0]         xOut,
  output logic               aLoad,
  output logic [7:0]         aOut,
  output logic               ccrLoad,
  output logic [7:0]         ccrOut,
  output logic               spLoad,
  output logic [15:0]        spOut,
  output logic               qWr,
  output logic [1:0]         qIdx,
  output logic [7:0]         qData
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  seqCtl_t ctl;
  logic anyReq;
  logic [IDX_W-1:0] winIdx;

  irq_seq_prio #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) prio_i (
    .req(irqReq), .anyReq(anyReq), .winIdx(winIdx)
  );

  irq_seq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .instrDone(instrDone), .anyReq(anyReq),
    .swiReq(swiReq), .rtiReq(rtiReq), .maskBit(ccrIn[I_BIT]),
    .ctl(ctl), .busy(busy)
  );

  irq_seq_dp #(.IDX_W(IDX_W), .I_BIT(I_BIT), .VEC_TOP(VEC_TOP), .SWI_VEC(SWI_VEC)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .curAny(anyReq), .curIdx(winIdx),
    .pcIn(pcIn), .xIn(xIn), .aIn(aIn), .ccrIn(ccrIn), .spIn(spIn),
    .memRdata(memRdata), .memAddr(memAddr), .memWr(memWr), .memRd(memRd),
    .memWdata(memWdata), .pcLoad(pcLoad), .pcOut(pcOut), .xLoad(xLoad),
    .xOut(xOut), .aLoad(aLoad), .aOut(aOut), .ccrLoad(ccrLoad),
    .ccrOut(ccrOut), .spLoad(spLoad), .spOut(spOut), .qWr(qWr),
    .qIdx(qIdx), .qData(qData)
  );
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
  parameter int I_BIT = 3
) (
  input logic        clk,
  input logic        rstN,
  input logic        instrDone,
  input logic        swiReq,
  input logic        maskBit,
  input logic        busy,
  input logic        memWr,
  input logic        memRd,
  input logic [15:0] memAddr,
  input logic        ccrLoad,
  input logic [7:0]  ccrOut,
  input logic        qWr,
  input logic [1:0]  qIdx,
  input logic        pcLoad
);
  // R10
  no_rdwr_clash_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memWr && memRd));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memWr && !memRd && !qWr));

  // R2
  push_descend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWr && $past(memWr)) |-> (memAddr == $past(memAddr) - 16'd1));

  // R3
  mask_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ccrLoad && $past(memWr)) |-> ccrOut[I_BIT]);

  // R1
  masked_no_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busy) && memWr) |-> ($past(instrDone) && ($past(swiReq) || !$past(maskBit))));

  // R6
  fill_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (qWr && $past(qWr)) |-> (qIdx == $past(qIdx) + 2'd1 && memAddr == $past(memAddr) + 16'd1));

  // R6
  fill_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && $past(qWr)) |-> ($past(qIdx) == 2'd2 && $past(pcLoad)));
endmodule

bind irq_seq irq_seq_chk #(.I_BIT(I_BIT)) chk_i (
  .clk(clk), .rstN(rstN), .instrDone(instrDone), .swiReq(swiReq),
  .maskBit(ccrIn[I_BIT]), .busy(busy), .memWr(memWr), .memRd(memRd),
  .memAddr(memAddr), .ccrLoad(ccrLoad), .ccrOut(ccrOut), .qWr(qWr),
  .qIdx(qIdx), .pcLoad(pcLoad)
);

// File: tb/irq_seq_tb_top.sv
`timescale 1ns/1ps
module irq_seq_tb_top;
  localparam int N = 8;
  localparam logic [15:0] SWI_TGT = 16'h7020;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instrDone = 1'b0, swiReq = 1'b0, rtiReq = 1'b0;
  logic [N-1:0] irqReq = '0;
  logic [15:0] memAddr, pcOut, spOut;
  logic memWr, memRd, busy, pcLoad, xLoad, aLoad, ccrLoad, spLoad, qWr;
  logic [7:0] memWdata, memRdata, xOut, aOut, ccrOut, qData;
  logic [1:0] qIdx;

  // CPU register model
  logic [15:0] pc = '0, sp = '0;
  logic [7:0] x = '0, a = '0, ccr = '0;
  logic cpuSet = 1'b0;
  logic [15:0] setPc = '0, setSp = '0;
  logic [7:0] setX = '0, setA = '0, setCcr = '0;
  logic [7:0] stackMem [256];
  logic [7:0] qMem [3];
  logic [15:0] fillAddr [3];

  int checks = 0, errs = 0;

  always #10 clk = ~clk;

  irq_seq dut_i (
    .clk(clk), .rstN(rstN), .instrDone(instrDone), .irqReq(irqReq),
    .swiReq(swiReq), .rtiReq(rtiReq), .pcIn(pc), .xIn(x), .aIn(a),
    .ccrIn(ccr), .spIn(sp), .memAddr(memAddr), .memWr(memWr), .memRd(memRd),
    .memWdata(memWdata), .memRdata(memRdata), .busy(busy), .pcLoad(pcLoad),
    .pcOut(pcOut), .xLoad(xLoad), .xOut(xOut), .aLoad(aLoad), .aOut(aOut),
    .ccrLoad(ccrLoad), .ccrOut(ccrOut), .spLoad(spLoad), .spOut(spOut),
    .qWr(qWr), .qIdx(qIdx), .qData(qData)
  );

  function automatic logic [15:0] tgtOf(input int k);
    return 16'h8010 + 16'(k) * 16'h0100;
  endfunction

  function automatic logic [7:0] progByte(input logic [15:0] ad);
    return ad[7:0] ^ ad[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] romByte(input logic [15:0] ad);
    logic [15:0] t;
    int k;
    if (ad[15:1] == 15'h7FFE) return ad[0] ? SWI_TGT[7:0] : SWI_TGT[15:8];
    if (ad >= 16'hFFFA - 16'(2 * (N - 1)) && ad <= 16'hFFFB) begin
      k = int'((16'hFFFA - {ad[15:1], 1'b0}) >> 1);
      t = tgtOf(k);
      return ad[0] ? t[7:0] : t[15:8];
    end
    return progByte(ad);
  endfunction

  always_comb begin
    if (memAddr[15:8] == 8'h01) memRdata = stackMem[memAddr[7:0]];
    else memRdata = romByte(memAddr);
  end

  always @(posedge clk) begin
    if (cpuSet) begin
      pc <= setPc; x <= setX; a <= setA; ccr <= setCcr; sp <= setSp;
    end else begin
      if (pcLoad) pc <= pcOut;
      if (xLoad) x <= xOut;
      if (aLoad) a <= aOut;
      if (ccrLoad) ccr <= ccrOut;
      if (spLoad) sp <= spOut;
    end
    if (memWr && memAddr[15:8] == 8'h01) stackMem[memAddr[7:0]] <= memWdata;
    if (qWr) begin
      qMem[qIdx] <= qData;
      fillAddr[qIdx] <= memAddr;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setCpu(input logic [15:0] p, input logic [7:0] xv, input logic [7:0] av,
                        input logic [7:0] c, input logic [15:0] s);
    @(negedge clk);
    setPc = p; setX = xv; setA = av; setCcr = c; setSp = s; cpuSet = 1'b1;
    @(negedge clk);
    cpuSet = 1'b0;
  endtask

  // pulse instrDone, count busy cycles; optionally change irqReq mid-sequence
  task automatic runSeq(output int busyCyc, input logic [N-1:0] lateVal, input int lateAt);
    int n;
    @(negedge clk);
    instrDone = 1'b1;
    @(negedge clk);
    instrDone = 1'b0;
    n = 0;
    while (busy && n < 100) begin
      n++;
      if (n == lateAt) irqReq = lateVal;
      @(negedge clk);
    end
    busyCyc = n;
  endtask

  task automatic verifyEntry(input string tag, input logic [15:0] sp0, input logic [15:0] pc0,
                             input logic [7:0] x0, input logic [7:0] a0, input logic [7:0] c0,
                             input logic [15:0] tgt, input int cyc);
    check({tag, " R8 busy cycles"}, 32'(cyc), 32'd10);
    check({tag, " R2 PCL"}, {24'd0, stackMem[sp0[7:0]]}, {24'd0, pc0[7:0]});
    check({tag, " R2 PCH"}, {24'd0, stackMem[8'(sp0[7:0] - 8'd1)]}, {24'd0, pc0[15:8]});
    check({tag, " R2 X"}, {24'd0, stackMem[8'(sp0[7:0] - 8'd2)]}, {24'd0, x0});
    check({tag, " R2 A"}, {24'd0, stackMem[8'(sp0[7:0] - 8'd3)]}, {24'd0, a0});
    check({tag, " R2 CCR"}, {24'd0, stackMem[8'(sp0[7:0] - 8'd4)]}, {24'd0, c0});
    check({tag, " R3 sp"}, {16'd0, sp}, {16'd0, sp0 - 16'd5});
    check({tag, " R3 ccr"}, {24'd0, ccr}, {24'd0, c0 | 8'h08});
    for (int i = 0; i < 3; i++) begin
      check({tag, " R6 fill addr"}, {16'd0, fillAddr[i]}, {16'd0, tgt + 16'(i)});
      check({tag, " R6 fill data"}, {24'd0, qMem[i]}, {24'd0, progByte(tgt + 16'(i))});
    end
    check({tag, " R6 pc"}, {16'd0, pc}, {16'd0, tgt + 16'd3});
  endtask

  task automatic verifyReturn(input string tag, input logic [15:0] sp0, input logic [15:0] pc0,
                              input logic [7:0] x0, input logic [7:0] a0, input logic [7:0] c0,
                              input int cyc);
    check({tag, " R8 busy cycles"}, 32'(cyc), 32'd5);
    check({tag, " R7 pc"}, {16'd0, pc}, {16'd0, pc0});
    check({tag, " R7 x"}, {24'd0, x}, {24'd0, x0});
    check({tag, " R7 a"}, {24'd0, a}, {24'd0, a0});
    check({tag, " R7 ccr"}, {24'd0, ccr}, {24'd0, c0});
    check({tag, " R7 sp"}, {16'd0, sp}, {16'd0, sp0});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL R8 watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : main
    int cyc;
    logic [15:0] sp0, pc0, pcA;
    logic [7:0] x0, a0, c0, cA;
    for (int i = 0; i < 256; i++) stackMem[i] = 8'h00;

    // R9 reset state
    repeat (3) @(negedge clk);
    check("R9 busy in reset", {31'd0, busy}, 32'd0);
    check("R9 strobes in reset", {28'd0, memWr, memRd, qWr, pcLoad}, 32'd0);
    check("R9 loads in reset", {28'd0, ccrLoad, spLoad, aLoad, xLoad}, 32'd0);
    rstN = 1'b1;

    // R4 sweep: each line with all less urgent lines pending; R7 return
    for (int k = 0; k < N; k++) begin
      pc0 = 16'h2000 + 16'(k) * 16'h0011; x0 = 8'h30 + 8'(k); a0 = 8'hA0 + 8'(k);
      c0 = (k % 2 == 1) ? 8'h41 : 8'h02; sp0 = 16'h01F0;
      setCpu(pc0, x0, a0, c0, sp0);
      irqReq = N'((1 << N) - (1 << k));
      runSeq(cyc, '0, -1);
      verifyEntry($sformatf("R4 sweep line %0d", k), sp0, pc0, x0, a0, c0, tgtOf(k), cyc);
      irqReq = '0;
      rtiReq = 1'b1;
      runSeq(cyc, '0, -1);
      rtiReq = 1'b0;
      verifyReturn($sformatf("R7 sweep line %0d", k), sp0, pc0, x0, a0, c0, cyc);
    end

    // R1: masked request and missing boundary start nothing
    setCpu(16'h2222, 8'h01, 8'h02, 8'h08, 16'h01F0);
    irqReq = N'(1);
    runSeq(cyc, N'(1), -1);
    check("R1 masked request ignored", 32'(cyc), 32'd0);
    check("R1 masked pc unchanged", {16'd0, pc}, 32'h2222);
    setCpu(16'h2222, 8'h01, 8'h02, 8'h00, 16'h01F0);
    repeat (4) @(negedge clk);
    check("R1 no boundary no entry", {31'd0, busy}, 32'd0);
    irqReq = '0;

    // R4: more urgent line raised during stacking
    setCpu(16'h2400, 8'h11, 8'h22, 8'h00, 16'h01F0);
    irqReq = N'(1 << 5);
    runSeq(cyc, N'((1 << 5) | (1 << 1)), 2);
    verifyEntry("R4 late urgent", 16'h01F0, 16'h2400, 8'h11, 8'h22, 8'h00, tgtOf(1), cyc);
    irqReq = '0;

    // R4: request dropped before vector read falls back to start source
    setCpu(16'h2500, 8'h12, 8'h23, 8'h00, 16'h01F0);
    irqReq = N'(1 << 4);
    runSeq(cyc, '0, 1);
    verifyEntry("R4 dropped request", 16'h01F0, 16'h2500, 8'h12, 8'h23, 8'h00, tgtOf(4), cyc);

    // R5: software interrupt with mask set
    setCpu(16'h2600, 8'h13, 8'h24, 8'h08, 16'h01E0);
    swiReq = 1'b1;
    runSeq(cyc, '0, -1);
    swiReq = 1'b0;
    verifyEntry("R5 swi masked", 16'h01E0, 16'h2600, 8'h13, 8'h24, 8'h08, SWI_TGT, cyc);

    // R5: hardware request wins at the same boundary, then swi runs nested
    setCpu(16'h2700, 8'h14, 8'h25, 8'h00, 16'h01E0);
    irqReq = N'(1 << 2);
    swiReq = 1'b1;
    runSeq(cyc, N'(1 << 2), -1);
    verifyEntry("R5 irq before swi", 16'h01E0, 16'h2700, 8'h14, 8'h25, 8'h00, tgtOf(2), cyc);
    irqReq = '0;
    pcA = pc; cA = ccr;
    runSeq(cyc, '0, -1);
    swiReq = 1'b0;
    verifyEntry("R5 swi nested", 16'h01DB, pcA, 8'h14, 8'h25, cA, SWI_TGT, cyc);

    // nesting after ISR clears the mask, masked pending then return
    setCpu(16'h3000, 8'h01, 8'h02, 8'h00, 16'h01F0);
    irqReq = N'(1 << 3);
    runSeq(cyc, N'(1 << 3), -1);
    verifyEntry("R2 outer", 16'h01F0, 16'h3000, 8'h01, 8'h02, 8'h00, tgtOf(3), cyc);
    irqReq = '0;
    pcA = pc;
    setCpu(pcA, 8'h55, 8'h66, 8'h00, 16'h01EB);
    irqReq = N'(1 << 1);
    runSeq(cyc, N'(1 << 1), -1);
    verifyEntry("R3 nested", 16'h01EB, pcA, 8'h55, 8'h66, 8'h00, tgtOf(1), cyc);
    irqReq = N'(1 << 6);
    runSeq(cyc, N'(1 << 6), -1);
    check("R1 pending masked in ISR", 32'(cyc), 32'd0);
    rtiReq = 1'b1;
    runSeq(cyc, N'(1 << 6), -1);
    rtiReq = 1'b0;
    verifyReturn("R7 inner return", 16'h01EB, pcA, 8'h55, 8'h66, 8'h00, cyc);
    runSeq(cyc, N'(1 << 6), -1);
    verifyEntry("R1 pending after return", 16'h01EB, pcA, 8'h55, 8'h66, 8'h00, tgtOf(6), cyc);
    irqReq = '0;

    // R10: strobes idle afterwards
    @(negedge clk);
    check("R10 idle strobes", {30'd0, memWr, memRd}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule